// File: doc/BRIEF.md
# Display DMA Channel Controller

This block holds the software-visible control registers of one display DMA channel and sequences its blocks. Software writes a set of 16-bit registers: the source start address, the source end address, the element step, the row step, the data format, the source port and the addressing mode. These form the programmed set. At the start of a run the controller copies the programmed set into an active set, and the active set drives the address generator. Software can rewrite the programmed set while a block is in flight without disturbing it. The new values reach the address generator only when software requests it with an end-of-programming bit, and then only at the next block boundary.

A block runs only while both the channel run bit and the external-controller enable bit are set. The controller pulses `blk_start` toward the address generator and waits for `blk_done`. At each completion it sets a sticky completion flag. If auto-init and repeat are both selected, it starts the next block by itself. Otherwise it clears the run bit and returns to idle. The interrupt line is the completion flag ANDed with its enable, and software acknowledges the flag by writing one to it.

The sequencer has five states. IDLE waits for run and external enable. LOAD copies the programmed set into the active set. ISSUE pulses the start strobe. BUSY waits for completion. WRAP records the completion and picks what follows. The transitions are:
- IDLE→LOAD on go.
- LOAD→ISSUE.
- ISSUE→BUSY.
- BUSY→IDLE when go drops, or BUSY→WRAP on done.
- WRAP→LOAD when repeating with a pending reload.
- WRAP→ISSUE when repeating without a pending reload.
- WRAP→IDLE otherwise.

Top module: `disp_dma_chan`

## Requirements
- R1: After reset, every register reads 0, `ext_ctrl_en`, `irq` and `blk_start` are low, and all active-set outputs are 0.
- R2: Register offsets are as follows:
  - Offset 0 is channel control. Bit 7 is run, bit 8 is auto-init, bit 9 is repeat, bit 11 is the end-of-programming request, and bits 13:12 are the addressing mode.
  - Offset 1 is display control. Bit 1 is the interrupt enable, bit 3 is the completion flag, bits 7:6 are the source port (0 = SDRAM), and bit 8 is the external-controller enable.
  - Offset 2 is the format register. Bits 1:0 are the data-type code.
  - Offsets 3/4 are the start address high/low, offsets 5/6 are the end address high/low, offset 7 is the element step, and offsets 8/9 are the row step high/low.
  - A read returns the stored fields combinationally. Unused bits and unused offsets read 0.
- R3: `blk_start` pulses for exactly one cycle, two cycles after the write that makes run and the external-controller enable both 1. Nothing starts while either is 0. `ext_ctrl_en` mirrors display-control bit 8.
- R4: The active set is loaded from the programmed set when a run starts. Programmed-set writes made later, including across a boundary without a reload request, leave the active outputs unchanged.
- R5: Writing 1 to channel-control bit 11 sets a pending reload, which reads back as 1. At the next boundary of a repeating run, the programmed set is copied into the active set, the next `blk_start` comes one cycle later than without a reload, and bit 11 reads 0 again.
- R6: A run repeats only when bits 8 and 9 are both 1. After a completion it pulses `blk_start` again one cycle after the completion is recorded. With bit 8 alone set, the run is single-shot.
- R7: In single-shot operation the completion clears the run bit, and no further `blk_start` appears. Auto-init and the other bits keep their values.
- R8: Each completion sets the flag in the same cycle. `irq` equals flag AND enable, so a flag set while the enable is 0 raises `irq` only once the enable is written to 1.
- R9: Writing display control with bit 3 = 1 clears the flag. Writing it with bit 3 = 0 leaves the flag unchanged. A write can never set the flag.
- R10: Clearing the run bit during a block stops the channel. A later `blk_done` is ignored: no completion is recorded and no new start is issued.
- R11: `act_dbl_index` is 1 exactly when the active mode bits are 2'b11. `act_port` and `act_fmt` carry the source port and data type captured at load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register offset for write and read |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Combinational read data at `reg_addr` |
| ext_ctrl_en | output | 1 | External-controller enable |
| irq | output | 1 | Block-complete interrupt |
| blk_start | output | 1 | One-cycle block start to the address generator |
| blk_done | input | 1 | Block completion from the address generator |
| act_src_begin | output | 2*DATA_W | Active start address |
| act_src_end | output | 2*DATA_W | Active end address |
| act_elem_step | output | DATA_W | Active element step |
| act_row_step | output | 2*DATA_W | Active row (frame) step |
| act_fmt | output | 2 | Active data-type code |
| act_port | output | 2 | Active source port |
| act_dbl_index | output | 1 | Active double-indexed addressing |

## Verification
Each result has a fixed cycle at which it is due:
- Register writes show on reads and on `irq` right after the write edge.
- `blk_start` is high in the second cycle after the enabling write, together with the freshly loaded active outputs.
- After `blk_done` is sampled, the completion flag, the cleared run bit and any repeat `blk_start` appear one cycle later.
- A boundary with a pending reload delays the start and the new active values by one further cycle.

The bench drives and samples on falling edges and counts exactly these edges before each check. For the stop and single-shot cases it also holds `blk_start` low over several following cycles.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ISSUE,
        ST_BUSY,
        ST_WRAP
    } seq_state_t;

    // register offsets
    localparam int OFS_CHAN   = 0;
    localparam int OFS_DISP   = 1;
    localparam int OFS_FMT    = 2;
    localparam int WORD_BASE  = 3;   // first address/index word
    localparam int N_WORDS    = 7;   // begin hi/lo, end hi/lo, elem step, row step hi/lo

    // channel-control bit positions
    localparam int CB_RUN     = 7;
    localparam int CB_AUTO    = 8;
    localparam int CB_RPT     = 9;
    localparam int CB_EOP     = 11;
    localparam int CB_MODE    = 12;

    // display-control bit positions
    localparam int DB_IEN     = 1;
    localparam int DB_DONE    = 3;
    localparam int DB_PORT    = 6;
    localparam int DB_EXT     = 8;

endpackage

// File: rtl/ddc_prog_regs.sv
module ddc_prog_regs
    import ddc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      hw_run_clr,
    input  logic                      hw_done_set,
    input  logic                      eop_take,
    output logic [DATA_W-1:0]         rdata,
    output logic                      run_en,
    output logic                      auto_bit,
    output logic                      rpt_bit,
    output logic                      eop_pend,
    output logic [1:0]                mode,
    output logic                      ien,
    output logic                      done_st,
    output logic [1:0]                port,
    output logic                      ext_en,
    output logic [1:0]                fmt,
    output logic [N_WORDS*DATA_W-1:0] words
);

    logic wr_chan, wr_disp, wr_fmt;

    assign wr_chan = we && (addr == ADDR_W'(OFS_CHAN));
    assign wr_disp = we && (addr == ADDR_W'(OFS_DISP));
    assign wr_fmt  = we && (addr == ADDR_W'(OFS_FMT));

    // channel control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            auto_bit <= 1'b0;
            rpt_bit  <= 1'b0;
            mode     <= 2'b00;
        end else begin
            if (wr_chan) begin
                run_en   <= wdata[CB_RUN];
                auto_bit <= wdata[CB_AUTO];
                rpt_bit  <= wdata[CB_RPT];
                mode     <= wdata[CB_MODE +: 2];
            end
            if (hw_run_clr) begin
                run_en <= 1'b0;   // completion of a single-shot block wins
            end
        end
    end

    // pending reload request: set by software, cleared when honoured
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eop_pend <= 1'b0;
        end else if (wr_chan && wdata[CB_EOP]) begin
            eop_pend <= 1'b1;
        end else if (eop_take) begin
            eop_pend <= 1'b0;
        end
    end

    // display control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien    <= 1'b0;
            port   <= 2'b00;
            ext_en <= 1'b0;
        end else if (wr_disp) begin
            ien    <= wdata[DB_IEN];
            port   <= wdata[DB_PORT +: 2];
            ext_en <= wdata[DB_EXT];
        end
    end

    // completion flag: hardware set, write-one-to-clear, set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_st <= 1'b0;
        end else if (hw_done_set) begin
            done_st <= 1'b1;
        end else if (wr_disp && wdata[DB_DONE]) begin
            done_st <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt <= 2'b00;
        end else if (wr_fmt) begin
            fmt <= wdata[1:0];
        end
    end

    // address and index words
    for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_word
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (addr == ADDR_W'(WORD_BASE + gi))) begin
                q <= wdata;
            end
        end
        assign words[gi*DATA_W +: DATA_W] = q;
    end

    // read mux
    always_comb begin
        int widx;
        rdata = '0;
        widx  = int'(addr) - WORD_BASE;
        if (addr == ADDR_W'(OFS_CHAN)) begin
            rdata[CB_RUN]      = run_en;
            rdata[CB_AUTO]     = auto_bit;
            rdata[CB_RPT]      = rpt_bit;
            rdata[CB_EOP]      = eop_pend;
            rdata[CB_MODE +: 2] = mode;
        end else if (addr == ADDR_W'(OFS_DISP)) begin
            rdata[DB_IEN]      = ien;
            rdata[DB_DONE]     = done_st;
            rdata[DB_PORT +: 2] = port;
            rdata[DB_EXT]      = ext_en;
        end else if (addr == ADDR_W'(OFS_FMT)) begin
            rdata[1:0] = fmt;
        end else if (widx >= 0 && widx < N_WORDS) begin
            rdata = words[widx*DATA_W +: DATA_W];
        end
    end

    // R8: the flag only rises when the sequencer records a completion
    a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_st) |-> $past(hw_done_set));

    // R9: acknowledge with no competing completion clears the flag
    a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_disp && wdata[DB_DONE] && !hw_done_set) |=> !done_st);

    // R5: a honoured reload with no new request leaves nothing pending
    a_r5_eop_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_take && !(wr_chan && wdata[CB_EOP])) |=> !eop_pend);

endmodule

// File: rtl/ddc_active_set.sv
module ddc_active_set
    import ddc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [N_WORDS*DATA_W-1:0] words_in,
    input  logic [1:0]                fmt_in,
    input  logic [1:0]                port_in,
    input  logic [1:0]                mode_in,
    output logic [N_WORDS*DATA_W-1:0] words_out,
    output logic [1:0]                fmt_out,
    output logic [1:0]                port_out,
    output logic                      dbl_index
);

    logic [1:0] mode_q;

    for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_act
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (load) begin
                q <= words_in[gi*DATA_W +: DATA_W];
            end
        end
        assign words_out[gi*DATA_W +: DATA_W] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_out  <= 2'b00;
            port_out <= 2'b00;
            mode_q   <= 2'b00;
        end else if (load) begin
            fmt_out  <= fmt_in;
            port_out <= port_in;
            mode_q   <= mode_in;
        end
    end

    assign dbl_index = (mode_q == 2'b11);

endmodule

// File: rtl/ddc_sequencer.sv
module ddc_sequencer
    import ddc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic repeat_en,
    input  logic eop_pend,
    input  logic blk_done,
    output logic blk_start,
    output logic load,
    output logic eop_take,
    output logic run_clr,
    output logic done_set
);

    seq_state_t state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (go) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_BUSY;
            ST_BUSY: begin
                if (!go) begin
                    state_nx = ST_IDLE;
                end else if (blk_done) begin
                    state_nx = ST_WRAP;
                end
            end
            ST_WRAP: begin
                if (repeat_en && go) begin
                    state_nx = eop_pend ? ST_LOAD : ST_ISSUE;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        blk_start = 1'b0;
        load      = 1'b0;
        eop_take  = 1'b0;
        run_clr   = 1'b0;
        done_set  = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_LOAD: begin
                load     = 1'b1;
                eop_take = 1'b1;
            end
            ST_ISSUE: blk_start = 1'b1;
            ST_BUSY:  ;
            ST_WRAP: begin
                done_set = 1'b1;
                run_clr  = !repeat_en;
            end
            default:  ;
        endcase
    end

    // R3: start strobe lasts a single cycle
    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> !blk_start);

    // R3: the channel stays idle without go
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !go) |=> (state == ST_IDLE));

    // R7: a non-repeating completion returns to idle
    a_r7_single_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRAP && !repeat_en) |=> (state == ST_IDLE));

    // R10: losing go while busy abandons the block
    a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !go) |=> (state == ST_IDLE));

endmodule

// File: rtl/disp_dma_chan.sv
module disp_dma_chan
    import ddc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  ext_ctrl_en,
    output logic                  irq,
    output logic                  blk_start,
    input  logic                  blk_done,
    output logic [2*DATA_W-1:0]   act_src_begin,
    output logic [2*DATA_W-1:0]   act_src_end,
    output logic [DATA_W-1:0]     act_elem_step,
    output logic [2*DATA_W-1:0]   act_row_step,
    output logic [1:0]            act_fmt,
    output logic [1:0]            act_port,
    output logic                  act_dbl_index
);

    localparam int SET_W = N_WORDS * DATA_W;

    logic             run_en, auto_bit, rpt_bit, eop_pend, ien, done_st, ext_en;
    logic [1:0]       mode, port, fmt;
    logic [SET_W-1:0] prog_words, act_words;
    logic             load_w, eop_take_w, run_clr_w, done_set_w;

    ddc_prog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .hw_run_clr (run_clr_w),
        .hw_done_set(done_set_w),
        .eop_take   (eop_take_w),
        .rdata      (reg_rdata),
        .run_en     (run_en),
        .auto_bit   (auto_bit),
        .rpt_bit    (rpt_bit),
        .eop_pend   (eop_pend),
        .mode       (mode),
        .ien        (ien),
        .done_st    (done_st),
        .port       (port),
        .ext_en     (ext_en),
        .fmt        (fmt),
        .words      (prog_words)
    );

    ddc_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (run_en && ext_en),
        .repeat_en (auto_bit && rpt_bit),
        .eop_pend  (eop_pend),
        .blk_done  (blk_done),
        .blk_start (blk_start),
        .load      (load_w),
        .eop_take  (eop_take_w),
        .run_clr   (run_clr_w),
        .done_set  (done_set_w)
    );

    ddc_active_set #(.DATA_W(DATA_W)) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_w),
        .words_in  (prog_words),
        .fmt_in    (fmt),
        .port_in   (port),
        .mode_in   (mode),
        .words_out (act_words),
        .fmt_out   (act_fmt),
        .port_out  (act_port),
        .dbl_index (act_dbl_index)
    );

    // word order: begin hi, begin lo, end hi, end lo, elem step, row hi, row lo
    assign act_src_begin = {act_words[0*DATA_W +: DATA_W], act_words[1*DATA_W +: DATA_W]};
    assign act_src_end   = {act_words[2*DATA_W +: DATA_W], act_words[3*DATA_W +: DATA_W]};
    assign act_elem_step = act_words[4*DATA_W +: DATA_W];
    assign act_row_step  = {act_words[5*DATA_W +: DATA_W], act_words[6*DATA_W +: DATA_W]};

    assign ext_ctrl_en = ext_en;
    assign irq         = done_st && ien;

    // R4: the active set moves only on a sequencer load
    a_r4_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_w |=> ($stable(act_src_begin) && $stable(act_row_step)));

    // R8: the interrupt rises only after a completion or a register write
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(done_set_w) || $past(reg_we)));

endmodule

// File: tb/tb_disp_dma_chan.sv
module tb_disp_dma_chan;

    localparam int DW = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          ext_ctrl_en, irq, blk_start;
    logic          blk_done = 1'b0;
    logic [2*DW-1:0] act_src_begin, act_src_end, act_row_step;
    logic [DW-1:0] act_elem_step;
    logic [1:0]    act_fmt, act_port;
    logic          act_dbl_index;

    int checks = 0;
    int failures = 0;

    disp_dma_chan #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_ctrl_en(ext_ctrl_en),
        .irq(irq), .blk_start(blk_start), .blk_done(blk_done),
        .act_src_begin(act_src_begin), .act_src_end(act_src_end),
        .act_elem_step(act_elem_step), .act_row_step(act_row_step),
        .act_fmt(act_fmt), .act_port(act_port), .act_dbl_index(act_dbl_index)
    );

    always #5 clk = ~clk;

    // offset, write data, expected read-back
    localparam int NV = 12;
    localparam logic [35:0] VEC [NV] = '{
        {4'd2, 16'hFFFF, 16'h0003},
        {4'd3, 16'h1234, 16'h1234},
        {4'd4, 16'hABCD, 16'hABCD},
        {4'd5, 16'h0042, 16'h0042},
        {4'd6, 16'h8000, 16'h8000},
        {4'd7, 16'h0005, 16'h0005},
        {4'd8, 16'hFFFF, 16'hFFFF},
        {4'd9, 16'h0010, 16'h0010},
        {4'd1, 16'h00C2, 16'h00C2},
        {4'd1, 16'h0000, 16'h0000},
        {4'd0, 16'h3000, 16'h3000},
        {4'd15, 16'hFFFF, 16'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_done();
        blk_done = 1'b1;
        @(negedge clk);
        blk_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd(4'd0, v); check("R1 chan", 32'(v), 32'h0);
        rd(4'd1, v); check("R1 disp", 32'(v), 32'h0);
        check("R1 irq/start/ext", {29'd0, irq, blk_start, ext_ctrl_en}, 32'h0);
        check("R1 active", act_src_begin, 32'h0);

        // R2 register table
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][35:32], VEC[i][31:16]);
            rd(VEC[i][35:32], v);
            check("R2 readback", 32'(v), 32'(VEC[i][15:0]));
        end

        // R3 run without external enable does nothing
        wr(4'd0, 16'h0080);
        for (int i = 0; i < 4; i++) begin
            step(1);
            check("R3 no start without ext", 32'(blk_start), 32'h0);
        end
        wr(4'd1, 16'h0100);
        check("R3 ext mirror", 32'(ext_ctrl_en), 32'h1);
        step(1);
        check("R3 not yet", 32'(blk_start), 32'h0);
        step(1);
        check("R3 start due", 32'(blk_start), 32'h1);
        check("R4 begin loaded", act_src_begin, 32'h1234ABCD);
        check("R4 end loaded", act_src_end, 32'h00428000);
        check("R4 row step loaded", act_row_step, 32'hFFFF0010);
        check("R11 fmt loaded", 32'(act_fmt), 32'h3);
        step(1);
        check("R3 single pulse", 32'(blk_start), 32'h0);

        // R4 write during block; R7 single shot; R8 flag without enable
        wr(4'd3, 16'h5555);
        check("R4 active held", act_src_begin, 32'h1234ABCD);
        pulse_done();
        step(1);
        check("R8 irq masked", 32'(irq), 32'h0);
        rd(4'd1, v); check("R8 flag set", 32'(v), 32'h0108);
        rd(4'd0, v); check("R7 run cleared", 32'(v), 32'h0);
        for (int i = 0; i < 3; i++) begin
            step(1);
            check("R7 no restart", 32'(blk_start), 32'h0);
        end
        wr(4'd1, 16'h0102);
        check("R8 irq on enable", 32'(irq), 32'h1);
        wr(4'd1, 16'h0102);
        rd(4'd1, v); check("R9 write zero keeps flag", 32'(v), 32'h010A);
        wr(4'd1, 16'h010A);
        rd(4'd1, v); check("R9 write one clears", 32'(v), 32'h0102);
        check("R9 irq low", 32'(irq), 32'h0);

        // R6 auto-init alone is single shot
        wr(4'd0, 16'h0180);
        step(2);
        check("R6 start", 32'(blk_start), 32'h1);
        check("R4 reload at start", act_src_begin, 32'h5555ABCD);
        step(1);
        pulse_done();
        step(1);
        check("R8 irq on completion", 32'(irq), 32'h1);
        rd(4'd0, v); check("R6 auto only stops", 32'(v), 32'h0100);
        for (int i = 0; i < 3; i++) begin
            step(1);
            check("R6 no repeat", 32'(blk_start), 32'h0);
        end
        wr(4'd1, 16'h010A);

        // R6 repeat, R11 double index, R5 end-of-programming
        wr(4'd0, 16'h3380);
        step(2);
        check("R6 repeat start", 32'(blk_start), 32'h1);
        check("R11 dbl index", 32'(act_dbl_index), 32'h1);
        step(1);
        wr(4'd3, 16'h7777);
        pulse_done();
        step(1);
        check("R6 auto restart", 32'(blk_start), 32'h1);
        check("R8 irq repeat", 32'(irq), 32'h1);
        check("R4 no reload at boundary", act_src_begin, 32'h5555ABCD);
        wr(4'd1, 16'h010A);
        check("R9 ack", 32'(irq), 32'h0);
        wr(4'd0, 16'h3B80);
        rd(4'd0, v); check("R5 pending read", 32'(v), 32'h3B80);
        check("R5 not yet applied", act_src_begin, 32'h5555ABCD);
        pulse_done();
        step(1);
        check("R5 reload cycle", 32'(blk_start), 32'h0);
        step(1);
        check("R5 start after reload", 32'(blk_start), 32'h1);
        check("R5 new active", act_src_begin, 32'h7777ABCD);
        rd(4'd0, v); check("R5 pending cleared", 32'(v), 32'h3380);
        wr(4'd1, 16'h010A);

        // R10 stop mid-block
        wr(4'd0, 16'h3300);
        pulse_done();
        for (int i = 0; i < 3; i++) begin
            step(1);
            check("R10 no start after stop", 32'(blk_start), 32'h0);
        end
        rd(4'd1, v); check("R10 no completion", 32'(v), 32'h0102);
        check("R10 irq low", 32'(irq), 32'h0);

        // R11 port and format capture
        wr(4'd1, 16'h01C2);
        wr(4'd2, 16'h0001);
        wr(4'd0, 16'h0080);
        step(2);
        check("R11 start", 32'(blk_start), 32'h1);
        check("R11 port", 32'(act_port), 32'h3);
        check("R11 fmt", 32'(act_fmt), 32'h1);
        check("R11 single index", 32'(act_dbl_index), 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule